// File: doc/BRIEF.md
# Serial Layered Min-Sum Check-Node Element

This block does the check-node work of a layered LDPC decoder for one check node at a time. At the start of a layer it takes the compressed record of that check node and its per-edge sign bits from the previous iteration. It then accepts the a-posteriori (APP) value of each connected variable node, one edge per cycle, tagged with the edge position. For each edge it rebuilds the old check-to-variable message, subtracts it from the APP value, and parks the variable-to-check result in a position-addressed buffer. While the edges arrive it tracks the two smallest magnitudes, where the smallest occurred, and the sign parity. Cycles where no edge is offered are allowed and leave everything untouched.

Once the last edge has arrived, a second pass walks the buffer in position order. It emits one updated APP value per cycle, computed with normalized min-sum (scale 0.75). On the cycle of the last emitted value it presents the new compressed record and the new sign bits, which the surrounding memory stores for the next iteration. For the first iteration the caller supplies an all-zero record and all-positive signs, so every old message is zero.

The control is a three-state machine. IDLE moves to GATHER when `layer_start` is high with a non-zero row weight. GATHER moves to EMIT when the edge count reaches the row weight. EMIT moves back to IDLE after the last position is emitted. No other transitions exist.

Top module: `lmsp_pe`

## Requirements
- R1: After reset, `out_valid` and `rec_valid` are low and stay low until a layer has been started and fed.
- R2: A record packs min1 magnitude in bits [4:0], min2 magnitude in bits [9:5] and the min1 position in bits [14:10]. The old message for edge p has magnitude min2 if p equals the stored position and min1 otherwise, and it is negative when bit p of `sgn_in` is 1.
- R3: The variable-to-check value of edge p is the APP input minus the old message of R2, saturated to 8-bit signed, and it is kept under position p.
- R4: The new record holds min1 and min2 of the variable-to-check magnitudes, each clipped to 31 before the search. A strictly smaller value replaces min1, so on ties the earliest arrival keeps the position. min2 stays 31 when only one edge exists. Both stored magnitudes are scaled as m - (m >> 2).
- R5: The new message for edge p has the scaled min2 as its magnitude if p is the recorded position, and the scaled min1 otherwise. It is negative when the XOR of the sign bits of all other edges' variable-to-check values is 1, where a negative value has sign 1.
- R6: Updated APP values are the variable-to-check value plus the new message, emitted on consecutive cycles with `out_valid` high and `out_pos` counting 0 up to row weight minus 1.
- R7: `rec_valid` pulses together with the last emitted APP value. In that cycle `rec_out` carries the new record and bit p of `sgn_out` is 1 when the new message of edge p is negative; bits at or above the row weight are 0.
- R8: In GATHER, cycles with `in_valid` low change no result: outputs equal those of the same layer fed with no gaps.
- R9: Every sum and difference saturates to the range -128 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| layer_start | input | 1 | Begins a layer when the block is idle |
| row_weight | input | 5 | Number of edges of the check node, 1 to 22 |
| rec_in | input | 15 | Compressed record from the previous iteration |
| sgn_in | input | 22 | Old message signs, one per edge position |
| in_valid | input | 1 | An edge is offered this cycle |
| in_pos | input | 5 | Position of the offered edge |
| in_app | input | 8 | APP value of the offered edge, signed |
| out_valid | output | 1 | Updated APP value present |
| out_pos | output | 5 | Position of the updated APP value |
| out_app | output | 8 | Updated APP value, signed |
| rec_valid | output | 1 | New record and signs present |
| rec_out | output | 15 | New compressed record |
| sgn_out | output | 22 | New message signs |

## Verification
The bench builds the block with its default parameters: 8-bit APP values, 6-bit messages and 22 edge positions. At these values the 5-bit position field and the 22-entry buffer are exercised at their ends. Row weights of 1 and 22 are reached, the min1 position can sit at 21, and the clip to 31 matters because 8-bit magnitudes go far beyond it. APP values near both rails, combined with old messages of either sign, drive both saturation limits.

// File: rtl/lmsp_pkg.sv
package lmsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_EMIT   = 2'd2
    } lmsp_state_e;
endpackage

// File: rtl/lmsp_minfind.sv
module lmsp_minfind #(
    parameter int MAG_W = 5,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [MAG_W-1:0] mag,
    input  logic [IDX_W-1:0] pos,
    input  logic             neg,
    output logic [MAG_W-1:0] m1,
    output logic [MAG_W-1:0] m2,
    output logic [IDX_W-1:0] idx,
    output logic             parity
);
    localparam logic [MAG_W-1:0] TOP = '1;

    logic [MAG_W-1:0] m1_q, m2_q;
    logic [IDX_W-1:0] idx_q;
    logic             par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_q  <= TOP;
            m2_q  <= TOP;
            idx_q <= '0;
            par_q <= 1'b0;
        end else if (clr) begin
            m1_q  <= TOP;
            m2_q  <= TOP;
            idx_q <= '0;
            par_q <= 1'b0;
        end else if (en) begin
            par_q <= par_q ^ neg;
            if (mag < m1_q) begin
                m2_q  <= m1_q;
                m1_q  <= mag;
                idx_q <= pos;
            end else if (mag < m2_q) begin
                m2_q <= mag;
            end
        end
    end

    assign m1     = m1_q;
    assign m2     = m2_q;
    assign idx    = idx_q;
    assign parity = par_q;

    // R4: the running first minimum never exceeds the second
    a_r4_min_order: assert property (@(posedge clk) disable iff (!rst_n)
        m1_q <= m2_q);

    // R8: a cycle with no edge leaves the search state alone
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(m1_q) && $stable(m2_q) && $stable(idx_q) && $stable(par_q)));
endmodule

// File: rtl/lmsp_v2c_buf.sv
module lmsp_v2c_buf #(
    parameter int DEPTH = 22,
    parameter int W     = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] ent_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == IDX_W'(g))) ent_q <= wdata;
        end
        assign ent_arr[g] = ent_q;
    end

    assign rdata = ent_arr[raddr];
endmodule

// File: rtl/lmsp_pe.sv
module lmsp_pe #(
    parameter int APP_W   = 8,
    parameter int C2V_W   = 6,
    parameter int MAX_DEG = 22
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   layer_start,
    input  logic [$clog2(MAX_DEG+1)-1:0]                           row_weight,
    input  logic [2*(C2V_W-1)+$clog2(MAX_DEG)-1:0]                 rec_in,
    input  logic [MAX_DEG-1:0]                                     sgn_in,
    input  logic                                                   in_valid,
    input  logic [$clog2(MAX_DEG)-1:0]                             in_pos,
    input  logic [APP_W-1:0]                                       in_app,
    output logic                                                   out_valid,
    output logic [$clog2(MAX_DEG)-1:0]                             out_pos,
    output logic [APP_W-1:0]                                       out_app,
    output logic                                                   rec_valid,
    output logic [2*(C2V_W-1)+$clog2(MAX_DEG)-1:0]                 rec_out,
    output logic [MAX_DEG-1:0]                                     sgn_out
);
    import lmsp_pkg::*;

    localparam int MAG_W = C2V_W - 1;
    localparam int IDX_W = $clog2(MAX_DEG);
    localparam int CNT_W = $clog2(MAX_DEG + 1);
    localparam int REC_W = 2 * MAG_W + IDX_W;
    localparam int SUM_W = APP_W + 2;
    localparam logic signed [SUM_W-1:0] HI_LIM  = SUM_W'((2 ** (APP_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO_LIM  = SUM_W'(-(2 ** (APP_W - 1)));
    localparam logic [APP_W:0]          MAG_CAP = (APP_W+1)'((2 ** MAG_W) - 1);

    function automatic logic [APP_W-1:0] sat_app(input logic [SUM_W-1:0] x);
        if ($signed(x) > HI_LIM)      return HI_LIM[APP_W-1:0];
        else if ($signed(x) < LO_LIM) return LO_LIM[APP_W-1:0];
        else                          return x[APP_W-1:0];
    endfunction

    function automatic logic [MAG_W-1:0] scale_mag(input logic [MAG_W-1:0] m);
        return m - (m >> 2);
    endfunction

    function automatic logic [SUM_W-1:0] signed_msg(input logic neg, input logic [MAG_W-1:0] m);
        logic [SUM_W-1:0] e;
        e = {{(SUM_W-MAG_W){1'b0}}, m};
        return neg ? (~e + 1'b1) : e;
    endfunction

    lmsp_state_e state_q, state_nxt;

    logic [CNT_W-1:0]   rw_q, cnt_q;
    logic [IDX_W-1:0]   ecnt_q;
    logic [REC_W-1:0]   rec_q;
    logic [MAX_DEG-1:0] sgnin_q;

    logic accept, edge_en, gather_done, emit_last;
    assign accept      = (state_q == ST_IDLE) && layer_start && (row_weight != '0);
    assign edge_en     = (state_q == ST_GATHER) && in_valid;
    assign gather_done = edge_en && ((cnt_q + CNT_W'(1)) == rw_q);
    assign emit_last   = (state_q == ST_EMIT) && (CNT_W'(ecnt_q) == (rw_q - CNT_W'(1)));

    // gather side: rebuild old message, form variable-to-check value
    logic [MAG_W-1:0] old_m1, old_m2, old_mag;
    logic [IDX_W-1:0] old_idx;
    logic [SUM_W-1:0] app_ext, diff;
    logic [APP_W-1:0] v2c;
    logic [APP_W:0]   v2c_abs;
    logic [MAG_W-1:0] v2c_mag;

    always_comb begin
        old_m1  = rec_q[MAG_W-1:0];
        old_m2  = rec_q[2*MAG_W-1:MAG_W];
        old_idx = rec_q[REC_W-1:2*MAG_W];
        old_mag = (in_pos == old_idx) ? old_m2 : old_m1;
        app_ext = {{2{in_app[APP_W-1]}}, in_app};
        diff    = app_ext - signed_msg(sgnin_q[in_pos], old_mag);
        v2c     = sat_app(diff);
        v2c_abs = v2c[APP_W-1] ? (~{1'b1, v2c} + 1'b1) : {1'b0, v2c};
        v2c_mag = (v2c_abs > MAG_CAP) ? MAG_CAP[MAG_W-1:0] : v2c_abs[MAG_W-1:0];
    end

    logic [MAG_W-1:0] mf_m1, mf_m2;
    logic [IDX_W-1:0] mf_idx;
    logic             mf_par;

    lmsp_minfind #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_minfind (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .en     (edge_en),
        .mag    (v2c_mag),
        .pos    (in_pos),
        .neg    (v2c[APP_W-1]),
        .m1     (mf_m1),
        .m2     (mf_m2),
        .idx    (mf_idx),
        .parity (mf_par)
    );

    logic [APP_W-1:0] buf_rd;

    lmsp_v2c_buf #(.DEPTH(MAX_DEG), .W(APP_W), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (edge_en),
        .waddr (in_pos),
        .wdata (v2c),
        .raddr (ecnt_q),
        .rdata (buf_rd)
    );

    // emit side: new message and updated APP value
    logic [MAG_W-1:0] new_mag;
    logic             new_neg;
    logic [APP_W-1:0] new_app;

    always_comb begin
        new_mag = (ecnt_q == mf_idx) ? scale_mag(mf_m2) : scale_mag(mf_m1);
        new_neg = mf_par ^ buf_rd[APP_W-1];
        new_app = sat_app({{2{buf_rd[APP_W-1]}}, buf_rd} + signed_msg(new_neg, new_mag));
    end

    // next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)      state_nxt = ST_GATHER;
            ST_GATHER: if (gather_done) state_nxt = ST_EMIT;
            ST_EMIT:   if (emit_last)   state_nxt = ST_IDLE;
            default:                    state_nxt = ST_IDLE;
        endcase
    end

    // state register and layer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rw_q    <= '0;
            rec_q   <= '0;
            sgnin_q <= '0;
            cnt_q   <= '0;
            ecnt_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                rw_q    <= row_weight;
                rec_q   <= rec_in;
                sgnin_q <= sgn_in;
                cnt_q   <= '0;
                ecnt_q  <= '0;
            end
            if (edge_en)                 cnt_q  <= cnt_q + CNT_W'(1);
            if (state_q == ST_EMIT)      ecnt_q <= emit_last ? '0 : ecnt_q + IDX_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pos   <= '0;
            out_app   <= '0;
            rec_valid <= 1'b0;
            rec_out   <= '0;
            sgn_out   <= '0;
        end else begin
            out_valid <= (state_q == ST_EMIT);
            rec_valid <= emit_last;
            if (accept) sgn_out <= '0;
            if (state_q == ST_EMIT) begin
                out_pos         <= ecnt_q;
                out_app         <= new_app;
                sgn_out[ecnt_q] <= new_neg;
            end
            if (emit_last) rec_out <= {mf_idx, scale_mag(mf_m2), scale_mag(mf_m1)};
        end
    end

    // R6: positions within one emit pass rise by one per cycle
    a_r6_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_pos == $past(out_pos) + IDX_W'(1)));

    // R6: every emit pass opens at position zero
    a_r6_first_pos: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_pos == '0));

    // R7: the record appears only beside the last updated APP value
    a_r7_rec_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (out_valid && (CNT_W'(out_pos) == rw_q - CNT_W'(1))));

    // R1: no output strobe follows straight out of an idle cycle without an emit pass
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !rec_valid);
endmodule

// File: tb/lmsp_pe_bench.sv
`timescale 1ns/1ps
module lmsp_pe_bench;
    localparam int NDEG = 22;
    localparam int NVEC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        layer_start = 1'b0;
    logic [4:0]  row_weight = '0;
    logic [14:0] rec_in = '0;
    logic [21:0] sgn_in = '0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_pos = '0;
    logic [7:0]  in_app = '0;
    logic        out_valid, rec_valid;
    logic [4:0]  out_pos;
    logic [7:0]  out_app;
    logic [14:0] rec_out;
    logic [21:0] sgn_out;

    always #2.5 clk = ~clk;

    lmsp_pe u_lmsp_pe (
        .clk(clk), .rst_n(rst_n), .layer_start(layer_start), .row_weight(row_weight),
        .rec_in(rec_in), .sgn_in(sgn_in), .in_valid(in_valid), .in_pos(in_pos),
        .in_app(in_app), .out_valid(out_valid), .out_pos(out_pos), .out_app(out_app),
        .rec_valid(rec_valid), .rec_out(rec_out), .sgn_out(sgn_out)
    );

    // stimulus vectors: row weight, old record, old signs, value seed, gap mask
    localparam logic [4:0]  T_RW   [NVEC] = '{5'd6, 5'd8, 5'd22, 5'd1, 5'd12, 5'd4};
    localparam logic [14:0] T_REC  [NVEC] = '{15'h0923, 15'h0000, 15'h57F1, 15'h0000, 15'h0314, 15'h0D4A};
    localparam logic [21:0] T_SGN  [NVEC] = '{22'h000005, 22'h000000, 22'h2AAAAA, 22'h000000, 22'h000FFF, 22'h000008};
    localparam int          T_SEED [NVEC] = '{1, 2, 3, 4, 5, 6};
    localparam logic [21:0] T_GAP  [NVEC] = '{22'h0, 22'h0000A5, 22'h100001, 22'h0, 22'h000800, 22'h0};

    int total = 0;
    int bad = 0;
    int cap_app [NDEG];
    int cap_n = 0;
    int order_err = 0;
    int rec_seen = 0;
    logic [14:0] cap_rec;
    logic [21:0] cap_sgn;
    logic signed [7:0] stim_app [NDEG];

    always @(negedge clk) begin
        if (out_valid) begin
            if (int'(out_pos) != cap_n) order_err++;
            if (out_pos < NDEG) cap_app[out_pos] = int'($signed(out_app));
            cap_n++;
        end
        if (rec_valid) begin
            cap_rec = rec_out;
            cap_sgn = sgn_out;
            rec_seen++;
        end
    end

    function automatic int sat8(input int x);
        if (x > 127) return 127;
        if (x < -128) return -128;
        return x;
    endfunction

    function automatic int scl(input int m);
        return m - (m >>> 2);
    endfunction

    task automatic check(input string req, input int got, input int exp, input int where);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s at %0d: actual=%0d expected=%0d", req, where, got, exp);
        end
    endtask

    task automatic run_layer(input int rw, input logic [14:0] rec, input logic [21:0] sgn,
                             input logic [21:0] gap, input string tag);
        int v [NDEG];
        int m1, m2, idx, par, seen0, cnt;
        m1 = 31; m2 = 31; idx = 0; par = 0;
        // R2 / R3 / R4 reference
        for (int p = 0; p < rw; p++) begin
            int om, ov, mg;
            om = (p == int'(rec[14:10])) ? int'(rec[9:5]) : int'(rec[4:0]);
            ov = sgn[p] ? -om : om;
            v[p] = sat8(int'(stim_app[p]) - ov);
            mg = (v[p] < 0) ? -v[p] : v[p];
            if (mg > 31) mg = 31;
            if (v[p] < 0) par ^= 1;
            if (mg < m1) begin m2 = m1; m1 = mg; idx = p; end
            else if (mg < m2) m2 = mg;
        end
        cap_n = 0; order_err = 0; seen0 = rec_seen;
        @(negedge clk);
        layer_start = 1'b1; row_weight = 5'(rw); rec_in = rec; sgn_in = sgn;
        @(negedge clk);
        layer_start = 1'b0;
        for (int p = 0; p < rw; p++) begin
            if (gap[p]) begin
                in_valid = 1'b0; in_pos = 5'(p); in_app = 8'h7F;
                @(negedge clk);
            end
            in_valid = 1'b1; in_pos = 5'(p); in_app = stim_app[p];
            @(negedge clk);
        end
        in_valid = 1'b0;
        cnt = 0;
        while (rec_seen == seen0 && cnt < 80) begin
            @(negedge clk);
            cnt++;
        end
        begin
            logic [21:0] es;
            es = '0;
            for (int p = 0; p < rw; p++) begin
                int nm, nv, nn;
                nm = (p == idx) ? scl(m2) : scl(m1);
                nn = par ^ ((v[p] < 0) ? 1 : 0);
                nv = nn ? -nm : nm;
                es[p] = nn[0];
                check({"R6 app ", tag}, cap_app[p], sat8(v[p] + nv), p);
            end
            check({"R6 count ", tag}, cap_n, rw, 0);
            check({"R6 order ", tag}, order_err, 0, 0);
            check({"R7 record ", tag}, int'(cap_rec), (idx << 10) | (scl(m2) << 5) | scl(m1), 0);
            check({"R7 signs ", tag}, int'(cap_sgn), int'(es), 0);
            check({"R7 strobe ", tag}, rec_seen - seen0, 1, 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check("R1 out_valid", int'(out_valid), 0, 0);
        check("R1 rec_valid", int'(rec_valid), 0, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 out_valid idle", int'(out_valid), 0, 1);
        check("R1 rec_valid idle", int'(rec_valid), 0, 1);

        // table walk: R2 R3 R4 R5 R6 R7, gaps cover R8
        for (int t = 0; t < NVEC; t++) begin
            for (int p = 0; p < NDEG; p++)
                stim_app[p] = 8'((T_SEED[t] * 71 + p * 29 + p * p * 13) & 255);
            run_layer(int'(T_RW[t]), T_REC[t], T_SGN[t], T_GAP[t],
                      (T_GAP[t] != '0) ? "R2 R3 R4 R5 R8" : "R2 R3 R4 R5");
        end

        // R9: saturation at both rails through old messages of either sign
        stim_app[0] = 8'sd127;  stim_app[1] = -8'sd128;
        stim_app[2] = 8'sd120;  stim_app[3] = -8'sd125;
        run_layer(4, 15'h0294, 22'h000005, 22'h0, "R9 rails");

        // R4: ties keep the earliest position, all magnitudes equal
        for (int p = 0; p < 5; p++) stim_app[p] = 8'sd9;
        run_layer(5, 15'h0, 22'h0, 22'h0, "R4 ties");

        // R8: same layer with and without gaps must agree
        for (int p = 0; p < 7; p++) stim_app[p] = 8'(p * 37 - 100);
        run_layer(7, 15'h1CA6, 22'h000041, 22'h000000, "R8 plain");
        run_layer(7, 15'h1CA6, 22'h000041, 22'h00007F, "R8 gapped");

        repeat (3) @(negedge clk);
        check("R1 idle after layers", int'(out_valid), 0, 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule